// File: doc/BRIEF.md
# Multi-Pass Matching Run Sequencer

This controller schedules the passes that a pattern-matching element array needs when one pass cannot cover the whole job. The job can be too large in two ways. The automaton may have more states than the array has physical elements, or the input stream may be longer than the on-chip input store. The controller divides the input into fixed-size chunks (2^CHUNK_LG bytes, 64K by default). It also divides the states into groups of 2^ELEM_LG elements. For every chunk, and within it for every state group, it runs the same four steps in sequence:

1. Load the array configuration.
2. Clear the input store.
3. Fill and stream the input.
4. Drain the collected match reports, which reach the output store through priority encoders.

Each step is a level enable that stays high until the unit that owns the step answers with its own completion pulse. While a pass runs, the controller publishes the group index and the byte offset and length of the current chunk, so that the memory side knows what to fetch.

The job is latched when a start request is accepted. The state count and the total input length are taken at that moment. When the final drain of the final chunk completes, a single-cycle completion strobe is raised and the controller returns to idle. A job with no states or no input bytes performs no passes and completes at once.

Top module: `run_phase_seq`

## Requirements
- R1: After reset, every step enable, `busy_o` and `done_o` are low, and `part_idx_o`, `chunk_base_o` and `chunk_len_o` are zero.
- R2: When `start_i` is high in idle with a non-empty job, `busy_o` and `cfg_go_o` rise in the next cycle. `start_i` has no effect while `busy_o` or `done_o` is high.
- R3: The steps run in the fixed order configure (`cfg_go_o`), clear (`ibuf_clr_o`), fill (`ibuf_fill_o`), drain (`obuf_drain_o`). A step's enable stays high until its own completion input is seen high at a clock edge, and the next step's enable is high in the following cycle. Completion inputs of other steps are ignored.
- R4: The number of state groups is ceil(`num_states_i` / 2^ELEM_LG). Within each chunk, `part_idx_o` takes the values 0, 1, ..., groups-1 in order, one value per four-step pass.
- R5: The number of chunks is ceil(`total_len_i` / 2^CHUNK_LG). Chunks are the outer loop, and `chunk_base_o` equals chunk index × 2^CHUNK_LG. The configure step therefore runs groups × chunks times per job.
- R6: While busy, `chunk_len_o` is 2^CHUNK_LG for every chunk except the last. For the last chunk it is `total_len_i` minus that chunk's base, which is always between 1 and 2^CHUNK_LG.
- R7: `done_o` is high for exactly one cycle. That cycle directly follows the clock edge at which the last drain completion was seen. After it the block is idle.
- R8: A job with zero states or zero length enables no step and raises `done_o` in the cycle after the start.
- R9: At most one of the four step enables and `done_o` is high at any time. Outside busy, `part_idx_o`, `chunk_base_o` and `chunk_len_o` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a job, accepted only in idle |
| num_states_i | input | STATE_W | Automaton state count, latched at start |
| total_len_i | input | LEN_W | Total input length in bytes, latched at start |
| cfg_done_i | input | 1 | Array configuration completed |
| iclr_done_i | input | 1 | Input store clear completed |
| fill_done_i | input | 1 | Input fill and streaming completed |
| drain_done_i | input | 1 | Report drain completed |
| cfg_go_o | output | 1 | Configure step enable |
| ibuf_clr_o | output | 1 | Input-store clear enable |
| ibuf_fill_o | output | 1 | Input fill and stream enable |
| obuf_drain_o | output | 1 | Report drain enable |
| part_idx_o | output | STATE_W-ELEM_LG+1 | Current state-group index |
| chunk_base_o | output | LEN_W | Byte offset of the current chunk |
| chunk_len_o | output | CHUNK_LG+1 | Byte length of the current chunk |
| busy_o | output | 1 | A job is running |
| done_o | output | 1 | One-cycle job completion strobe |

## Verification
The hardest conditions to reach are the wrap points: the last group of a chunk that is not the last chunk, and the final group of a short last chunk. At these points the group index returns to zero and the chunk index advances, or the job ends. The bench shrinks the chunk and group sizes through parameters, so that jobs of three chunks and many groups finish quickly. Completion pulses arrive after varying delays. Stray completions for inactive steps and repeated start requests are mixed in during a run. A behavioural reference model compares every output on every clock.

// File: rtl/run_phase_seq_pkg.sv
package run_phase_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CFG   = 3'd1,
        PH_ICLR  = 3'd2,
        PH_FILL  = 3'd3,
        PH_DRAIN = 3'd4,
        PH_DONE  = 3'd5
    } phase_e;
endpackage

// File: rtl/seq_ceil_shift.sv
// Rounded-up division by a power of two.
module seq_ceil_shift #(
    parameter int IN_W = 20,
    parameter int SH   = 12,
    localparam int OW  = IN_W - SH + 1
) (
    input  logic [IN_W-1:0] val_i,
    output logic [OW-1:0]   quo_o
);
    always_comb begin
        quo_o = OW'(val_i[IN_W-1:SH]) + OW'(|val_i[SH-1:0]);
    end
endmodule

// File: rtl/seq_chunk_geom.sv
// Offset, length and last flag of the chunk selected by an index.
module seq_chunk_geom #(
    parameter int LEN_W    = 32,
    parameter int CHUNK_LG = 16,
    localparam int CW      = LEN_W - CHUNK_LG + 1,
    localparam int LW      = CHUNK_LG + 1
) (
    input  logic [CW-1:0]    idx_i,
    input  logic [CW-1:0]    count_i,
    input  logic [LEN_W-1:0] total_i,
    output logic [LEN_W-1:0] base_o,
    output logic [LW-1:0]    len_o,
    output logic             last_o
);
    localparam logic [LW-1:0] FULL = LW'(1) << CHUNK_LG;

    always_comb begin
        base_o = LEN_W'(idx_i) << CHUNK_LG;
        last_o = (idx_i == (count_i - CW'(1)));
        len_o  = last_o ? LW'(total_i - base_o) : FULL;
    end
endmodule

// File: rtl/run_phase_seq.sv
module run_phase_seq
    import run_phase_seq_pkg::*;
#(
    parameter int STATE_W  = 20,
    parameter int ELEM_LG  = 12,
    parameter int LEN_W    = 32,
    parameter int CHUNK_LG = 16,
    localparam int PW      = STATE_W - ELEM_LG + 1,
    localparam int CW      = LEN_W - CHUNK_LG + 1,
    localparam int LW      = CHUNK_LG + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [STATE_W-1:0] num_states_i,
    input  logic [LEN_W-1:0]   total_len_i,
    input  logic               cfg_done_i,
    input  logic               iclr_done_i,
    input  logic               fill_done_i,
    input  logic               drain_done_i,
    output logic               cfg_go_o,
    output logic               ibuf_clr_o,
    output logic               ibuf_fill_o,
    output logic               obuf_drain_o,
    output logic [PW-1:0]      part_idx_o,
    output logic [LEN_W-1:0]   chunk_base_o,
    output logic [LW-1:0]      chunk_len_o,
    output logic               busy_o,
    output logic               done_o
);
    typedef struct packed {
        phase_e           ph;
        logic [PW-1:0]    parts;
        logic [PW-1:0]    part;
        logic [CW-1:0]    chunks;
        logic [CW-1:0]    chunk;
        logic [LEN_W-1:0] total;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [PW-1:0]    parts_w;
    logic [CW-1:0]    chunks_w;
    logic [LEN_W-1:0] base_w;
    logic [LW-1:0]    len_w;
    logic             last_chunk_w;
    logic             last_part_w;

    seq_ceil_shift #(.IN_W(STATE_W), .SH(ELEM_LG)) u_parts (
        .val_i (num_states_i),
        .quo_o (parts_w)
    );

    seq_ceil_shift #(.IN_W(LEN_W), .SH(CHUNK_LG)) u_chunks (
        .val_i (total_len_i),
        .quo_o (chunks_w)
    );

    seq_chunk_geom #(.LEN_W(LEN_W), .CHUNK_LG(CHUNK_LG)) u_geom (
        .idx_i   (st_q.chunk),
        .count_i (st_q.chunks),
        .total_i (st_q.total),
        .base_o  (base_w),
        .len_o   (len_w),
        .last_o  (last_chunk_w)
    );

    assign last_part_w = (st_q.part == (st_q.parts - PW'(1)));

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.parts  = parts_w;
                    st_d.chunks = chunks_w;
                    st_d.total  = total_len_i;
                    st_d.part   = '0;
                    st_d.chunk  = '0;
                    st_d.ph     = (parts_w == '0 || chunks_w == '0) ? PH_DONE : PH_CFG;
                end
            end
            PH_CFG:  if (cfg_done_i)  st_d.ph = PH_ICLR;
            PH_ICLR: if (iclr_done_i) st_d.ph = PH_FILL;
            PH_FILL: if (fill_done_i) st_d.ph = PH_DRAIN;
            PH_DRAIN: begin
                if (drain_done_i) begin
                    if (last_part_w) begin
                        st_d.part = '0;
                        if (last_chunk_w) begin
                            st_d.chunk = '0;
                            st_d.ph    = PH_DONE;
                        end else begin
                            st_d.chunk = st_q.chunk + CW'(1);
                            st_d.ph    = PH_CFG;
                        end
                    end else begin
                        st_d.part = st_q.part + PW'(1);
                        st_d.ph   = PH_CFG;
                    end
                end
            end
            PH_DONE: st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_go_o     = (st_q.ph == PH_CFG);
        ibuf_clr_o   = (st_q.ph == PH_ICLR);
        ibuf_fill_o  = (st_q.ph == PH_FILL);
        obuf_drain_o = (st_q.ph == PH_DRAIN);
        done_o       = (st_q.ph == PH_DONE);
        busy_o       = cfg_go_o | ibuf_clr_o | ibuf_fill_o | obuf_drain_o;
        part_idx_o   = busy_o ? st_q.part : '0;
        chunk_base_o = busy_o ? base_w : '0;
        chunk_len_o  = busy_o ? len_w : '0;
    end

    // R9: only one step (or the completion strobe) at a time
    a_r9_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_go_o, ibuf_clr_o, ibuf_fill_o, obuf_drain_o, done_o}));

    // R7: completion strobe lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: ordering of the steps
    a_r3_cfg_then_clr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_go_o) |-> ibuf_clr_o);
    a_r3_clr_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ibuf_clr_o) |-> ibuf_fill_o);
    a_r3_fill_then_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ibuf_fill_o) |-> obuf_drain_o);
    a_r3_fill_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (ibuf_fill_o && !fill_done_i) |=> ibuf_fill_o);

    // R6: chunk length range while running
    a_r6_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (chunk_len_o != '0 && chunk_len_o <= (LW'(1) << CHUNK_LG)));

    // R4: group index stays inside the latched group count
    a_r4_part_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (part_idx_o < st_q.parts));
endmodule

// File: tb/sim_run_phase_seq.sv
module sim_run_phase_seq;
    localparam int STATE_W  = 8;
    localparam int ELEM_LG  = 3;
    localparam int LEN_W    = 10;
    localparam int CHUNK_LG = 4;
    localparam int PW = STATE_W - ELEM_LG + 1;
    localparam int LW = CHUNK_LG + 1;
    localparam int GRP = 1 << ELEM_LG;
    localparam int CHK = 1 << CHUNK_LG;

    logic clk = 0;
    logic rst_n = 0;
    logic start_i = 0;
    logic [STATE_W-1:0] num_states_i = '0;
    logic [LEN_W-1:0] total_len_i = '0;
    logic cfg_done_i = 0, iclr_done_i = 0, fill_done_i = 0, drain_done_i = 0;
    logic cfg_go_o, ibuf_clr_o, ibuf_fill_o, obuf_drain_o, busy_o, done_o;
    logic [PW-1:0] part_idx_o;
    logic [LEN_W-1:0] chunk_base_o;
    logic [LW-1:0] chunk_len_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    run_phase_seq #(.STATE_W(STATE_W), .ELEM_LG(ELEM_LG), .LEN_W(LEN_W),
                    .CHUNK_LG(CHUNK_LG)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .num_states_i(num_states_i), .total_len_i(total_len_i),
        .cfg_done_i(cfg_done_i), .iclr_done_i(iclr_done_i),
        .fill_done_i(fill_done_i), .drain_done_i(drain_done_i),
        .cfg_go_o(cfg_go_o), .ibuf_clr_o(ibuf_clr_o), .ibuf_fill_o(ibuf_fill_o),
        .obuf_drain_o(obuf_drain_o), .part_idx_o(part_idx_o),
        .chunk_base_o(chunk_base_o), .chunk_len_o(chunk_len_o),
        .busy_o(busy_o), .done_o(done_o));

    // Reference model: 0 idle, 1 cfg, 2 clear, 3 fill, 4 drain, 5 done
    int ms = 0, mp = 0, mc = 0, np = 0, nc = 0, mt = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms = 0; mp = 0; mc = 0;
        end else begin
            case (ms)
                0: if (start_i) begin
                    np = (int'(num_states_i) + GRP - 1) / GRP;
                    nc = (int'(total_len_i) + CHK - 1) / CHK;
                    mt = int'(total_len_i);
                    mp = 0; mc = 0;
                    ms = (np == 0 || nc == 0) ? 5 : 1;
                end
                1: if (cfg_done_i) ms = 2;
                2: if (iclr_done_i) ms = 3;
                3: if (fill_done_i) ms = 4;
                4: if (drain_done_i) begin
                    if (mp == np - 1) begin
                        mp = 0;
                        if (mc == nc - 1) begin mc = 0; ms = 5; end
                        else begin mc = mc + 1; ms = 1; end
                    end else begin
                        mp = mp + 1; ms = 1;
                    end
                end
                default: ms = 0;
            endcase
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at cycle %0d", req, got, exp, cycles);
        end
    endtask

    int cfg_rises = 0;
    int done_seen = 0;
    logic cfg_prev = 0;

    task automatic compare_all();
        int busy_e;
        busy_e = (ms >= 1 && ms <= 4) ? 1 : 0;
        chk("R3 cfg_go_o", int'(cfg_go_o), int'(ms == 1));
        chk("R3 ibuf_clr_o", int'(ibuf_clr_o), int'(ms == 2));
        chk("R3 ibuf_fill_o", int'(ibuf_fill_o), int'(ms == 3));
        chk("R3 obuf_drain_o", int'(obuf_drain_o), int'(ms == 4));
        chk("R7 done_o", int'(done_o), int'(ms == 5));
        chk("R2 busy_o", int'(busy_o), busy_e);
        chk("R4 part_idx_o", int'(part_idx_o), busy_e ? mp : 0);
        chk("R5 chunk_base_o", int'(chunk_base_o), busy_e ? mc * CHK : 0);
        chk("R6 chunk_len_o", int'(chunk_len_o),
            busy_e ? ((mc == nc - 1) ? mt - mc * CHK : CHK) : 0);
        chk("R9 one active", $countones({cfg_go_o, ibuf_clr_o, ibuf_fill_o,
            obuf_drain_o, done_o}) <= 1 ? 1 : 0, 1);
        if (cfg_go_o && !cfg_prev) cfg_rises++;
        cfg_prev = cfg_go_o;
        if (done_o) done_seen++;
    endtask

    task automatic cyc();
        @(negedge clk);
        cycles++;
        compare_all();
    endtask

    task automatic run_job(input int states, input int len, input bit noisy);
        int exp_p, exp_c, guard;
        exp_p = (states + GRP - 1) / GRP;
        exp_c = (len + CHK - 1) / CHK;
        cfg_rises = 0;
        done_seen = 0;
        num_states_i = STATE_W'(states);
        total_len_i = LEN_W'(len);
        start_i = 1;
        cyc();
        start_i = 0;
        if (exp_p == 0 || exp_c == 0) begin
            chk("R8 done right after start", int'(done_o), 1);
            chk("R8 no step enabled", int'(busy_o), 0);
        end else begin
            chk("R2 cfg after start", int'(cfg_go_o), 1);
        end
        guard = 0;
        while (ms != 0 && guard < 60000) begin
            cfg_done_i   = cfg_go_o     ? ($urandom_range(0, 1) == 1) : (noisy && $urandom_range(0, 3) == 0);
            iclr_done_i  = ibuf_clr_o   ? ($urandom_range(0, 1) == 1) : (noisy && $urandom_range(0, 3) == 0);
            fill_done_i  = ibuf_fill_o  ? ($urandom_range(0, 2) == 0) : (noisy && $urandom_range(0, 3) == 0);
            drain_done_i = obuf_drain_o ? ($urandom_range(0, 1) == 1) : (noisy && $urandom_range(0, 3) == 0);
            start_i = noisy && ($urandom_range(0, 3) == 0);
            cyc();
            guard++;
        end
        start_i = 0; cfg_done_i = 0; iclr_done_i = 0; fill_done_i = 0; drain_done_i = 0;
        chk("R7 job finished", int'(ms == 0), 1);
        chk("R7 single done strobe", done_seen, 1);
        chk("R5 configure passes = groups x chunks", cfg_rises, exp_p * exp_c);
        cyc();
        chk("R7 idle after done", int'(busy_o | done_o), 0);
    endtask

    initial begin
        #10000000;
        errors++;
        $display("FAIL watchdog: got hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(7));
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        // R1 reset state
        chk("R1 enables low", int'({cfg_go_o, ibuf_clr_o, ibuf_fill_o, obuf_drain_o}), 0);
        chk("R1 busy/done low", int'({busy_o, done_o}), 0);
        chk("R1 indices zero", int'(part_idx_o) + int'(chunk_base_o) + int'(chunk_len_o), 0);
        run_job(20, 40, 0);    // 3 groups, 3 chunks, last of 8
        run_job(8, 16, 1);     // exact fit, single pass
        run_job(1, 1, 1);      // minimal job, length 1
        run_job(0, 30, 1);     // R8 no states
        run_job(5, 0, 0);      // R8 no input
        run_job(64, 33, 1);    // 8 groups, last chunk of 1 byte
        run_job(255, 1023, 1); // largest values
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule